// File: doc/BRIEF.md
# Functional Unit Pool Scheduler

This block tracks how busy a pool of execution units is. Each unit serves a fixed set of operation classes. Each class has its own latency and is either pipelined or non-pipelined. An issue stage shows the pool one request per cycle, made of an operation class and a tag. The pool reports, for every class, whether some unit could take such an operation now. When it takes one, it hands the request to the lowest-indexed unit that can serve it. It then raises that unit's completion pulse, carrying the tag, exactly the class latency later. The arithmetic itself is not modelled; only occupancy and timing are.

Units are grouped by kind, and the groups are placed in this index order: simple integer ALUs, then integer multiply/divide units, float add/compare units, float multiply/divide units, memory units, and privileged-register units. The number of units in each group is a parameter. With the defaults the layout is ALU 0–1, multiply/divide 2, float add 3, float multiply 4, memory 5–6 and privileged 7. A flush input drops every operation in flight and frees every unit.

Top module: `fu_pool`

## Requirements
- R1: After reset no `done_valid` bit is high, and `class_avail` reads all ones for class codes 0..11.
- R2: Class codes and latencies are:
  - 0 integer ALU: 1
  - 1 integer multiply: 3
  - 2 integer divide: 1
  - 3 float add: 2
  - 4 float compare: 2
  - 5 float multiply: 4
  - 6 float multiply-accumulate: 5
  - 7 float divide: 12
  - 8 float square root: 24
  - 9 load: 1
  - 10 store: 1
  - 11 privileged register access: 3

  An operation accepted at clock edge k makes `done_valid[u]` high, with its tag on slice u of `done_tag`, during exactly the one cycle that follows edge k+L-1, where L is the class latency.
- R3: The pipelined classes are 0, 1, 3, 4, 5, 6, 9 and 10. A unit can accept one of them on every cycle.
- R4: The non-pipelined classes are 2, 7, 8 and 11. One of them accepted at edge k makes its unit refuse every class until the cycle after edge k+L-1. That is the cycle in which its pulse shows.
- R5: Units are shared between classes as follows:
  - one multiply/divide unit serves 1 and 2;
  - one float add unit serves 3 and 4;
  - one float multiply unit serves 5, 6, 7 and 8;
  - a memory unit serves 9 and 10.

  So a busy float divide or square root also blocks float multiply.
- R6: A request goes to the lowest-indexed unit that can accept its class. `iss_unit` gives that unit's index.
- R7: A unit refuses an operation whose completion cycle would fall on the completion cycle of an operation it already has in flight.
- R8: While `flush` is high, `iss_ready` is low. At that edge every operation in flight is cancelled and every unit is freed, so no later pulse appears for any of them.
- R9: `iss_ready` equals `class_avail[iss_class]` when `flush` is low. Class codes 12..15 are never ready.
- R10: A request presented while `iss_ready` is low is not taken and never produces a completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Cancel all in-flight operations and free all units |
| iss_valid | input | 1 | Issue request present |
| iss_class | input | 4 | Operation class code of the request |
| iss_tag | input | TAG_W | Tag returned with the completion |
| iss_ready | output | 1 | Request can be accepted this cycle |
| iss_unit | output | UNIT_W | Index of the unit chosen for the request |
| class_avail | output | 12 | Per-class availability this cycle |
| done_valid | output | N_UNITS | Per-unit completion pulse |
| done_tag | output | N_UNITS*TAG_W | Per-unit completion tag, unit u at bits u*TAG_W upward |

## Verification
The bench runs every class on an idle pool and times each pulse to the exact cycle. A design with a latency off by one, or one that puts the pulse on the wrong unit slice, shows up as an early, late or unmatched pulse.

It then holds a divide and a square root on the shared float multiply unit. This catches a pool that frees the unit a cycle early or late, or one that lets multiply through. It also catches a request taken while refused, because that request produces a stray pulse.

A multiply-accumulate followed one cycle later by a multiply targets the same completion cycle, so a design without slot checks would deliver two results on one cycle. A flush during a long square root must leave no pulse behind and must free the unit at once.

// File: rtl/fu_pool_pkg.sv
package fu_pool_pkg;

  localparam int NUM_CLASS = 12;

  typedef enum logic [3:0] {
    OP_IALU  = 4'd0,  OP_IMUL  = 4'd1,  OP_IDIV = 4'd2,
    OP_FADD  = 4'd3,  OP_FCMP  = 4'd4,  OP_FMUL = 4'd5,
    OP_FMAC  = 4'd6,  OP_FDIV  = 4'd7,  OP_FSQRT = 4'd8,
    OP_LOAD  = 4'd9,  OP_STORE = 4'd10, OP_PRIV = 4'd11
  } op_class_e;

  typedef enum logic [2:0] {
    K_ALU, K_MULDIV, K_FPADD, K_FPMUL, K_MEM, K_PRIV, K_NONE
  } unit_kind_e;

  function automatic int op_latency(int cls);
    case (cls)
      1, 11:   return 3;
      3, 4:    return 2;
      5:       return 4;
      6:       return 5;
      7:       return 12;
      8:       return 24;
      default: return 1;
    endcase
  endfunction

  function automatic bit op_pipelined(int cls);
    return !(cls == 2 || cls == 7 || cls == 8 || cls == 11);
  endfunction

  function automatic unit_kind_e op_kind(int cls);
    case (cls)
      0:             return K_ALU;
      1, 2:          return K_MULDIV;
      3, 4:          return K_FPADD;
      5, 6, 7, 8:    return K_FPMUL;
      9, 10:         return K_MEM;
      11:            return K_PRIV;
      default:       return K_NONE;
    endcase
  endfunction

  function automatic int max_latency();
    int m = 1;
    for (int c = 0; c < NUM_CLASS; c++)
      if (op_latency(c) > m) m = op_latency(c);
    return m;
  endfunction

  // Unit index -> kind, groups laid out in a fixed order
  function automatic unit_kind_e kind_of_unit(int u, int n_alu, int n_md,
                                              int n_fa, int n_fm, int n_mem);
    int b = n_alu;
    if (u < b) return K_ALU;
    b += n_md;  if (u < b) return K_MULDIV;
    b += n_fa;  if (u < b) return K_FPADD;
    b += n_fm;  if (u < b) return K_FPMUL;
    b += n_mem; if (u < b) return K_MEM;
    return K_PRIV;
  endfunction

endpackage

// File: rtl/fu_pick.sv
module fu_pick #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        found  = 1'b1;
      end
    end
    any = found;
  end

  always_comb begin
    p_gnt_in_req_r6: assert ((gnt & ~req) == '0)
      else $error("grant outside request set");
    p_gnt_lowest_r6: assert (((gnt - N'(1)) & req) == '0)
      else $error("grant not lowest requester");
  end

endmodule

// File: rtl/fu_unit.sv
module fu_unit
  import fu_pool_pkg::*;
#(
  parameter unit_kind_e KIND  = K_ALU,
  parameter int         TAG_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 take,
  input  logic [3:0]           take_cls,
  input  logic [TAG_W-1:0]     take_tag,
  output logic [NUM_CLASS-1:0] ok_vec,
  output logic                 done_v,
  output logic [TAG_W-1:0]     done_tag
);

  localparam int MAXLAT = max_latency();
  localparam int LAT_W  = $clog2(MAXLAT + 1);
  localparam int IDX_W  = (MAXLAT > 1) ? $clog2(MAXLAT) : 1;

  // vld[i]/tagq[i]: operation completing i+1 cycles from now
  logic [MAXLAT-1:0] vld;
  logic [TAG_W-1:0]  tagq [MAXLAT];
  logic [LAT_W-1:0]  busy_q;
  logic [LAT_W-1:0]  take_lat;
  logic [IDX_W-1:0]  take_slot;
  logic              take_pipe;
  logic [NUM_CLASS-1:0] slot_ok;

  always_comb begin
    take_lat  = LAT_W'(op_latency(int'(take_cls)));
    take_slot = IDX_W'(take_lat - LAT_W'(1));
    take_pipe = op_pipelined(int'(take_cls));
  end

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    localparam int L = op_latency(c);
    if (L >= MAXLAT) begin : g_last
      assign slot_ok[c] = 1'b1;
    end else begin : g_mid
      assign slot_ok[c] = !vld[L];
    end
    assign ok_vec[c] = (op_kind(c) == KIND) && (busy_q == '0) && slot_ok[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      busy_q <= '0;
      for (int i = 0; i < MAXLAT; i++) tagq[i] <= '0;
    end else if (flush) begin
      vld    <= '0;
      busy_q <= '0;
    end else begin
      vld <= vld >> 1;
      for (int i = 0; i < MAXLAT - 1; i++) tagq[i] <= tagq[i+1];
      if (take) begin
        vld[take_slot]  <= 1'b1;
        tagq[take_slot] <= take_tag;
      end
      if (take && !take_pipe) busy_q <= take_lat - LAT_W'(1);
      else if (busy_q != '0)  busy_q <= busy_q - LAT_W'(1);
    end
  end

  assign done_v   = vld[0];
  assign done_tag = tagq[0];

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q != '0) |-> (ok_vec == '0))
    else $error("busy unit offered a class");

  p_flush_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0 && busy_q == '0))
    else $error("flush left work in flight");

  p_lat1_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_lat == LAT_W'(1)) |=> (done_v && done_tag == $past(take_tag)))
    else $error("single-cycle op did not complete next cycle");

endmodule

// File: rtl/fu_pool.sv
module fu_pool
  import fu_pool_pkg::*;
#(
  parameter int N_ALU    = 2,
  parameter int N_MULDIV = 1,
  parameter int N_FPADD  = 1,
  parameter int N_FPMUL  = 1,
  parameter int N_MEM    = 2,
  parameter int N_PRIV   = 1,
  parameter int TAG_W    = 6,
  localparam int N_UNITS = N_ALU + N_MULDIV + N_FPADD + N_FPMUL + N_MEM + N_PRIV,
  localparam int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     iss_valid,
  input  logic [3:0]               iss_class,
  input  logic [TAG_W-1:0]         iss_tag,
  output logic                     iss_ready,
  output logic [UNIT_W-1:0]        iss_unit,
  output logic [NUM_CLASS-1:0]     class_avail,
  output logic [N_UNITS-1:0]       done_valid,
  output logic [N_UNITS*TAG_W-1:0] done_tag
);

  logic [NUM_CLASS-1:0] ok_u [N_UNITS];
  logic [NUM_CLASS-1:0] cls_hot;
  logic [N_UNITS-1:0]   req, gnt, take;
  logic                 any_unit;

  assign cls_hot = NUM_CLASS'(1) << iss_class;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    fu_unit #(
      .KIND  (kind_of_unit(u, N_ALU, N_MULDIV, N_FPADD, N_FPMUL, N_MEM)),
      .TAG_W (TAG_W)
    ) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .take     (take[u]),
      .take_cls (iss_class),
      .take_tag (iss_tag),
      .ok_vec   (ok_u[u]),
      .done_v   (done_valid[u]),
      .done_tag (done_tag[u*TAG_W +: TAG_W])
    );
    assign req[u]  = |(ok_u[u] & cls_hot);
    assign take[u] = iss_valid && iss_ready && gnt[u];
  end

  always_comb begin
    class_avail = '0;
    for (int u = 0; u < N_UNITS; u++) class_avail |= ok_u[u];
  end

  fu_pick #(.N(N_UNITS)) u_pick (
    .req (req),
    .gnt (gnt),
    .idx (iss_unit),
    .any (any_unit)
  );

  assign iss_ready = any_unit && !flush;

  p_one_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take))
    else $error("more than one unit took a request");

  p_refused_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |-> (take == '0))
    else $error("refused request was taken");

  p_ready_matches_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && iss_class < 4'(NUM_CLASS)) |-> (iss_ready == class_avail[iss_class]))
    else $error("ready disagrees with class availability");

endmodule

// File: tb/fu_pool_bench.sv
module fu_pool_bench;

  localparam int TW = 6;
  localparam int NU = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          iss_valid = 1'b0;
  logic [3:0]    iss_class = '0;
  logic [TW-1:0] iss_tag = '0;
  logic          iss_ready;
  logic [2:0]    iss_unit;
  logic [11:0]   class_avail;
  logic [NU-1:0] done_valid;
  logic [NU*TW-1:0] done_tag;

  fu_pool u_fu_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
    .iss_class(iss_class), .iss_tag(iss_tag), .iss_ready(iss_ready),
    .iss_unit(iss_unit), .class_avail(class_avail),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  int next_tag = 1;

  typedef struct { int due; int unit; int tag; } exp_t;
  exp_t sbq[$];

  function automatic int lat_of(int c);
    int t[12] = '{1, 3, 1, 2, 2, 4, 5, 12, 24, 1, 1, 3};
    return t[c];
  endfunction

  function automatic int unit_of(int c);
    int t[12] = '{0, 2, 2, 3, 3, 4, 4, 4, 4, 5, 5, 7};
    return t[c];
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Driver: present one request; push expectation if it must be taken
  task automatic issue(int c, bit exp_ok, string rq, output int at);
    @(negedge clk);
    iss_valid = 1'b1;
    iss_class = 4'(c);
    iss_tag   = TW'(next_tag);
    #1;
    at = cyc;
    chk(rq, "iss_ready", int'(iss_ready), int'(exp_ok));
    if (exp_ok) begin
      chk(rq, "iss_unit", int'(iss_unit), unit_of(c));
      sbq.push_back('{due: at + lat_of(c), unit: unit_of(c), tag: next_tag});
    end
    next_tag = (next_tag % 63) + 1;
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: match every completion pulse against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int u = 0; u < NU; u++) begin
        if (done_valid[u]) begin
          int t;
          bit found;
          t = int'(done_tag[u*TW +: TW]);
          found = 1'b0;
          for (int i = 0; i < sbq.size(); i++) begin
            if (!found && sbq[i].unit == u && sbq[i].tag == t) begin
              chk("R2", "completion cycle", cyc, sbq[i].due);
              sbq.delete(i);
              found = 1'b1;
            end
          end
          if (!found) begin
            nchk++; nfail++;
            $display("FAIL R10 stray pulse unit %0d: got tag %0h expected none", u, t);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int at;
    int t0;
    exp_t keep[$];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, R9 unknown class
    @(negedge clk); #1;
    chk("R1", "done_valid", int'(done_valid), 0);
    chk("R1", "class_avail", int'(class_avail), 12'hfff);
    iss_class = 4'd13; #1;
    chk("R9", "ready for code 13", int'(iss_ready), 0);

    // R2/R6 every class on an idle pool
    for (int c = 0; c < 12; c++) begin
      issue(c, 1'b1, "R2", at);
      idle(26);
    end

    // R3 back-to-back pipelined issue
    for (int k = 0; k < 3; k++) issue(0, 1'b1, "R3", at);
    for (int k = 0; k < 4; k++) issue(3 + (k % 2), 1'b1, "R3", at);
    for (int k = 0; k < 4; k++) issue(9 + (k % 2), 1'b1, "R3", at);
    idle(6);

    // R5 multiply and divide share unit 2
    issue(1, 1'b1, "R5", at);
    issue(2, 1'b1, "R5", at);
    idle(6);

    // R4/R5/R10 float divide blocks the float multiply unit
    issue(7, 1'b1, "R4", t0);
    issue(5, 1'b0, "R10", at);
    for (int k = 2; k <= 11; k++) begin
      @(negedge clk); #1;
      chk("R4", "fmul avail while div busy", int'(class_avail[5]), 0);
      chk("R5", "fadd avail while div busy", int'(class_avail[3]), 1);
    end
    @(negedge clk); #1;
    chk("R4", "cycle of release", cyc, t0 + 12);
    chk("R4", "fmul avail at release", int'(class_avail[5]), 1);
    idle(4);

    // R4 privileged access blocks its own unit for its latency
    issue(11, 1'b1, "R4", t0);
    issue(11, 1'b0, "R4", at);
    issue(11, 1'b0, "R4", at);
    issue(11, 1'b1, "R4", at);
    chk("R4", "priv reissue cycle", at, t0 + 3);
    idle(6);

    // R7 completion-slot conflict on the float multiply unit
    issue(6, 1'b1, "R7", at);
    issue(5, 1'b0, "R7", at);
    issue(5, 1'b1, "R7", at);
    idle(8);

    // R8 flush during a square root
    issue(8, 1'b1, "R8", at);
    idle(5);
    #1;
    chk("R5", "fmac avail while sqrt busy", int'(class_avail[6]), 0);
    @(negedge clk);
    flush = 1'b1; iss_valid = 1'b1; iss_class = 4'd0; iss_tag = TW'(63);
    #1;
    chk("R8", "iss_ready during flush", int'(iss_ready), 0);
    keep = {};
    foreach (sbq[i]) if (sbq[i].due <= cyc) keep.push_back(sbq[i]);
    sbq = keep;
    @(posedge clk);
    #1 flush = 1'b0; iss_valid = 1'b0;
    @(negedge clk); #1;
    chk("R8", "fmul avail after flush", int'(class_avail[5]), 1);
    idle(30);

    chk("R2", "outstanding expectations", sbq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule